// File: doc/BRIEF.md
# Exception Entry Vector Dispatcher

This block picks the handler entry offset that a pipelined processor jumps to when an event needs a handler. The events are reset, machine check, arithmetic trap, interrupt, data-stream error, instruction translation miss, instruction access violation, handler-call instruction, illegal opcode and floating-point disabled. A corrected hardware error is reported through the interrupt entry. An uncorrected error arrives as a machine check. Each cycle the highest-ranked raised event wins. One clock later the block presents its handler offset with a one-cycle dispatch strobe. It also registers the address the handler returns to.

A handler-call instruction carries an 8-bit function code. Codes 0x00 to 0x3F form the kernel-only bank at base 0x2000. Codes 0x80 to 0xBF form the open bank at base 0x3000. Each code owns a 64-byte slot. For these calls the return register holds the address of the following instruction, so the handler can return without adjusting it. Calls that may not use a slot become illegal-opcode traps. Events ranked above the data-stream group also raise a pulse. That pulse releases the memory-management status and fault-address capture registers.

A small state machine tracks the cycle. ST_RST is held while reset is high. ST_FIRE is entered in a cycle after a request is seen. ST_IDLE is entered in a cycle after no request is seen. The transitions run from any state to ST_RST on reset, from any state to ST_FIRE on a request, and from any state to ST_IDLE when nothing is raised. The strobe is high in ST_RST and ST_FIRE.

Top module: `exc_vector_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `vec_valid`=1, `vec_offset`=0x0000, `unlock`=1 and `ret_addr`=0.
- R2: A lone event maps to a fixed offset: machine check 0x0020, arithmetic 0x0060, interrupt 0x00E0, instruction translation miss 0x03E0, access violation 0x07E0, illegal opcode 0x13E0, floating-point disabled 0x17E0.
- R3: A data-stream error maps through `dserr_class`: 0 to 0x01E0, 1 to 0x08E0, 2 to 0x09E0, 3 to 0x11E0.
- R4: A call with code 0x00–0x3F while `in_kernel`=1 goes to 0x2000 + (code[5:0] << 6), and `ret_addr` takes `next_pc`.
- R5: A call with code 0x80–0xBF goes to 0x3000 + (code[5:0] << 6) in either mode, and `ret_addr` takes `next_pc`.
- R6: A call with code 0x00–0x3F while `in_kernel`=0 goes to 0x13E0, and `ret_addr` takes `fault_pc`.
- R7: A call with code 0x40–0x7F or 0xC0–0xFF goes to 0x13E0, and `ret_addr` takes `fault_pc`.
- R8: When several events are raised together, exactly one offset is issued. It belongs to the first raised event in this order: reset, machine check, arithmetic, interrupt (corrected errors included), data-stream error, translation miss, access violation, call, illegal opcode, floating-point disabled.
- R9: Every dispatch other than a slot-dispatched call loads `ret_addr` with `fault_pc`.
- R10: `unlock` is 1 in the strobe cycle of reset, machine check, arithmetic or interrupt, and 0 in every other cycle.
- R11: Outputs are registered and appear one cycle after the request. A cycle after no request shows `vec_valid`=0, and `vec_offset` and `ret_addr` unchanged.
- R12: A corrected hardware error (`req_corr`) dispatches to the interrupt entry 0x00E0 and asserts `unlock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, also the reset event |
| req_mchk | input | 1 | Uncorrected hardware error / machine check |
| req_arith | input | 1 | Arithmetic trap |
| req_intr | input | 1 | Interrupt |
| req_corr | input | 1 | Corrected hardware error, handled as interrupt |
| req_dserr | input | 1 | Data-stream error |
| dserr_class | input | 2 | Data-stream error class |
| req_itbm | input | 1 | Instruction translation miss |
| req_iacv | input | 1 | Instruction access violation |
| req_call | input | 1 | Handler-call instruction |
| call_func | input | 8 | Handler-call function code |
| in_kernel | input | 1 | Current mode is kernel |
| req_illop | input | 1 | Reserved or privileged opcode |
| req_fpdis | input | 1 | Floating-point disabled |
| fault_pc | input | PC_W | Address of the affected instruction |
| next_pc | input | PC_W | Address of the following instruction |
| vec_offset | output | OFF_W | Handler entry offset |
| vec_valid | output | 1 | Dispatch strobe |
| ret_addr | output | PC_W | Registered exception-return address |
| unlock | output | 1 | Release pulse for the status and fault-address capture registers |

## Verification
Two functions can land in the same cycle. One is the arbitration between ranked events. The other is the handler-call decode that can turn a call into an illegal-opcode trap. The bench raises every pair of events at once, and it also mixes calls of every code in both modes with random companions and occasional reset. A behavioural model predicts the single winning offset, the return source and the unlock pulse. It is compared with the ports every cycle, so a call that outranks or falls under another event is judged on both the offset and the return address.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    // Ranked events below reset; the enum order is the priority order.
    typedef enum logic [3:0] {
        EV_MCHK  = 4'd0,
        EV_ARITH = 4'd1,
        EV_INTR  = 4'd2,
        EV_DSERR = 4'd3,
        EV_ITBM  = 4'd4,
        EV_IACV  = 4'd5,
        EV_CALL  = 4'd6,
        EV_ILLOP = 4'd7,
        EV_FPDIS = 4'd8,
        EV_NONE  = 4'd9
    } ev_e;

    localparam int NUM_EV = 9;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_IDLE = 2'd1,
        ST_FIRE = 2'd2
    } st_e;

    localparam logic [15:0] OFS_RESET = 16'h0000;
    localparam logic [15:0] OFS_MCHK  = 16'h0020;
    localparam logic [15:0] OFS_ARITH = 16'h0060;
    localparam logic [15:0] OFS_INTR  = 16'h00E0;
    localparam logic [15:0] OFS_ITBM  = 16'h03E0;
    localparam logic [15:0] OFS_IACV  = 16'h07E0;
    localparam logic [15:0] OFS_ILLOP = 16'h13E0;
    localparam logic [15:0] OFS_FPDIS = 16'h17E0;
    localparam logic [15:0] OFS_KBANK = 16'h2000;
    localparam logic [15:0] OFS_OBANK = 16'h3000;

    function automatic logic [15:0] dserr_ofs(input logic [1:0] cls);
        unique case (cls)
            2'd0: dserr_ofs = 16'h01E0;
            2'd1: dserr_ofs = 16'h08E0;
            2'd2: dserr_ofs = 16'h09E0;
            default: dserr_ofs = 16'h11E0;
        endcase
    endfunction

endpackage

// File: rtl/exc_evt_priority.sv
module exc_evt_priority
    import exc_vec_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic [N-1:0] req,
    output ev_e          win,
    output logic         any
);

    // Scan from lowest rank up so the highest-ranked raised bit wins.
    always_comb begin
        win = EV_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = ev_e'(4'(i));
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/exc_call_decode.sv
module exc_call_decode
    import exc_vec_pkg::*;
#(
    parameter int OFF_W      = 16,
    parameter int SLOT_SHIFT = 6
) (
    input  logic [7:0]       func,
    input  logic             in_kernel,
    output logic             slot_ok,
    output logic [OFF_W-1:0] slot_off
);

    localparam int IDX_W = 6;

    logic             open_bank;
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] idx_sh;

    assign open_bank = func[7];
    // Bit 6 set is outside both banks; the kernel bank needs kernel mode.
    assign slot_ok   = !func[6] && (open_bank || in_kernel);
    assign base      = open_bank ? OFF_W'(OFS_OBANK) : OFF_W'(OFS_KBANK);
    assign idx_sh    = OFF_W'(func[IDX_W-1:0]) << SLOT_SHIFT;
    assign slot_off  = base + idx_sh;

endmodule

// File: rtl/exc_vec_select.sv
module exc_vec_select
    import exc_vec_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  ev_e              win,
    input  logic [1:0]       dserr_class,
    input  logic             slot_ok,
    input  logic [OFF_W-1:0] slot_off,
    output logic [OFF_W-1:0] sel_off,
    output logic             sel_unlock,
    output logic             sel_next
);

    always_comb begin
        sel_off    = OFF_W'(OFS_RESET);
        sel_unlock = 1'b0;
        sel_next   = 1'b0;
        unique case (win)
            EV_MCHK: begin
                sel_off    = OFF_W'(OFS_MCHK);
                sel_unlock = 1'b1;
            end
            EV_ARITH: begin
                sel_off    = OFF_W'(OFS_ARITH);
                sel_unlock = 1'b1;
            end
            EV_INTR: begin
                sel_off    = OFF_W'(OFS_INTR);
                sel_unlock = 1'b1;
            end
            EV_DSERR: sel_off = OFF_W'(dserr_ofs(dserr_class));
            EV_ITBM:  sel_off = OFF_W'(OFS_ITBM);
            EV_IACV:  sel_off = OFF_W'(OFS_IACV);
            EV_CALL: begin
                if (slot_ok) begin
                    sel_off  = slot_off;
                    sel_next = 1'b1;
                end else begin
                    sel_off  = OFF_W'(OFS_ILLOP);
                end
            end
            EV_ILLOP: sel_off = OFF_W'(OFS_ILLOP);
            EV_FPDIS: sel_off = OFF_W'(OFS_FPDIS);
            default:  sel_off = OFF_W'(OFS_RESET);
        endcase
    end

endmodule

// File: rtl/exc_vector_dispatch.sv
module exc_vector_dispatch
    import exc_vec_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int PC_W  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_mchk,
    input  logic             req_arith,
    input  logic             req_intr,
    input  logic             req_corr,
    input  logic             req_dserr,
    input  logic [1:0]       dserr_class,
    input  logic             req_itbm,
    input  logic             req_iacv,
    input  logic             req_call,
    input  logic [7:0]       call_func,
    input  logic             in_kernel,
    input  logic             req_illop,
    input  logic             req_fpdis,
    input  logic [PC_W-1:0]  fault_pc,
    input  logic [PC_W-1:0]  next_pc,
    output logic [OFF_W-1:0] vec_offset,
    output logic             vec_valid,
    output logic [PC_W-1:0]  ret_addr,
    output logic             unlock
);

    logic [NUM_EV-1:0] req_vec;
    ev_e               win;
    logic              any_req;
    logic              slot_ok;
    logic [OFF_W-1:0]  slot_off;
    logic [OFF_W-1:0]  sel_off;
    logic              sel_unlock;
    logic              sel_next;
    st_e               state;

    // Index 0 is the highest rank after reset.
    assign req_vec = {req_fpdis, req_illop, req_call, req_iacv, req_itbm,
                      req_dserr, req_intr | req_corr, req_arith, req_mchk};

    exc_evt_priority #(.N(NUM_EV)) u_prio (
        .req (req_vec),
        .win (win),
        .any (any_req)
    );

    exc_call_decode #(.OFF_W(OFF_W), .SLOT_SHIFT(6)) u_call (
        .func      (call_func),
        .in_kernel (in_kernel),
        .slot_ok   (slot_ok),
        .slot_off  (slot_off)
    );

    exc_vec_select #(.OFF_W(OFF_W)) u_sel (
        .win         (win),
        .dserr_class (dserr_class),
        .slot_ok     (slot_ok),
        .slot_off    (slot_off),
        .sel_off     (sel_off),
        .sel_unlock  (sel_unlock),
        .sel_next    (sel_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RST;
        end else if (any_req) begin
            state <= ST_FIRE;
        end else begin
            state <= ST_IDLE;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_offset <= OFF_W'(OFS_RESET);
            ret_addr   <= '0;
            unlock     <= 1'b1;
        end else if (any_req) begin
            vec_offset <= sel_off;
            ret_addr   <= sel_next ? next_pc : fault_pc;
            unlock     <= sel_unlock;
        end else begin
            unlock     <= 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            ST_RST:  vec_valid = 1'b1;
            ST_FIRE: vec_valid = 1'b1;
            default: vec_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/exc_vector_dispatch_chk.sv
module exc_vector_dispatch_chk #(
    parameter int OFF_W = 16,
    parameter int PC_W  = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             req_mchk,
    input logic             req_arith,
    input logic             req_intr,
    input logic             req_corr,
    input logic             req_dserr,
    input logic             req_itbm,
    input logic             req_iacv,
    input logic             req_call,
    input logic             req_illop,
    input logic             req_fpdis,
    input logic [PC_W-1:0]  next_pc,
    input logic [OFF_W-1:0] vec_offset,
    input logic             vec_valid,
    input logic [PC_W-1:0]  ret_addr,
    input logic             unlock
);

    logic primed = 1'b0;
    logic any_in;

    always_ff @(posedge clk) primed <= 1'b1;

    assign any_in = req_mchk | req_arith | req_intr | req_corr | req_dserr |
                    req_itbm | req_iacv | req_call | req_illop | req_fpdis;

    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (!primed)
        rst |=> (vec_valid && vec_offset == '0 && unlock));

    assert_slot_ret_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && req_call && !req_mchk && !req_arith && !req_intr && !req_corr &&
         !req_dserr && !req_itbm && !req_iacv)
        |=> (vec_offset[OFF_W-1:12] >= 2) == (ret_addr == $past(next_pc)) ||
            (vec_offset[OFF_W-1:12] < 2));

    assert_one_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
        any_in |=> vec_valid);

    assert_unlock_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        unlock |-> vec_valid);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !any_in |=> (!vec_valid && $stable(vec_offset) && $stable(ret_addr)));

    assert_slot_align_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_offset[OFF_W-1:12] >= 2) |-> vec_offset[5:0] == '0);

endmodule

bind exc_vector_dispatch exc_vector_dispatch_chk #(.OFF_W(OFF_W), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_mchk   (req_mchk),
    .req_arith  (req_arith),
    .req_intr   (req_intr),
    .req_corr   (req_corr),
    .req_dserr  (req_dserr),
    .req_itbm   (req_itbm),
    .req_iacv   (req_iacv),
    .req_call   (req_call),
    .req_illop  (req_illop),
    .req_fpdis  (req_fpdis),
    .next_pc    (next_pc),
    .vec_offset (vec_offset),
    .vec_valid  (vec_valid),
    .ret_addr   (ret_addr),
    .unlock     (unlock)
);

// File: tb/exc_vector_dispatch_tb.sv
module exc_vector_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_mchk, req_arith, req_intr, req_corr, req_dserr;
    logic [1:0]  dserr_class;
    logic        req_itbm, req_iacv, req_call, req_illop, req_fpdis;
    logic [7:0]  call_func;
    logic        in_kernel;
    logic [63:0] fault_pc, next_pc;
    logic [15:0] vec_offset;
    logic        vec_valid;
    logic [63:0] ret_addr;
    logic        unlock;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] e_off = 16'h0;
    logic [63:0] e_ret = 64'h0;
    logic        e_val, e_unl;
    string       e_tag;
    string       force_tag = "";

    always #5 clk = ~clk;

    exc_vector_dispatch u_dut (
        .clk(clk), .rst(rst), .req_mchk(req_mchk), .req_arith(req_arith),
        .req_intr(req_intr), .req_corr(req_corr), .req_dserr(req_dserr),
        .dserr_class(dserr_class), .req_itbm(req_itbm), .req_iacv(req_iacv),
        .req_call(req_call), .call_func(call_func), .in_kernel(in_kernel),
        .req_illop(req_illop), .req_fpdis(req_fpdis), .fault_pc(fault_pc),
        .next_pc(next_pc), .vec_offset(vec_offset), .vec_valid(vec_valid),
        .ret_addr(ret_addr), .unlock(unlock)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: walk the ranked list, first hit decides.
    task automatic predict();
        bit use_next = 0;
        e_val = 1; e_unl = 0;
        if (rst) begin
            e_off = 16'h0000; e_ret = 64'h0; e_unl = 1; e_tag = "R1";
            return;
        end
        if      (req_mchk)  begin e_off = 16'h0020; e_unl = 1; e_tag = "R2"; end
        else if (req_arith) begin e_off = 16'h0060; e_unl = 1; e_tag = "R2"; end
        else if (req_intr)  begin e_off = 16'h00E0; e_unl = 1; e_tag = "R2"; end
        else if (req_corr)  begin e_off = 16'h00E0; e_unl = 1; e_tag = "R12"; end
        else if (req_dserr) begin
            case (dserr_class)
                2'd0: e_off = 16'h01E0;
                2'd1: e_off = 16'h08E0;
                2'd2: e_off = 16'h09E0;
                default: e_off = 16'h11E0;
            endcase
            e_tag = "R3";
        end
        else if (req_itbm)  begin e_off = 16'h03E0; e_tag = "R2"; end
        else if (req_iacv)  begin e_off = 16'h07E0; e_tag = "R2"; end
        else if (req_call) begin
            int code = int'(call_func);
            if (code <= 'h3F && in_kernel) begin
                e_off = 16'h2000 + 16'(code * 64); use_next = 1; e_tag = "R4";
            end else if (code >= 'h80 && code <= 'hBF) begin
                e_off = 16'h3000 + 16'((code - 'h80) * 64); use_next = 1; e_tag = "R5";
            end else if (code <= 'h3F) begin
                e_off = 16'h13E0; e_tag = "R6";
            end else begin
                e_off = 16'h13E0; e_tag = "R7";
            end
        end
        else if (req_illop) begin e_off = 16'h13E0; e_tag = "R2"; end
        else if (req_fpdis) begin e_off = 16'h17E0; e_tag = "R2"; end
        else begin
            e_val = 0; e_tag = "R11";
            return;
        end
        e_ret = use_next ? next_pc : fault_pc;
    endtask

    task automatic cyc();
        string t;
        predict();
        @(negedge clk);
        t = (force_tag != "") ? force_tag : e_tag;
        chk(vec_valid == e_val, t, "vec_valid", 64'(vec_valid), 64'(e_val));
        chk(vec_offset == e_off, t, "vec_offset", 64'(vec_offset), 64'(e_off));
        chk(ret_addr == e_ret, (e_tag == "R4" || e_tag == "R5" || e_tag == "R1") ? t : "R9",
            "ret_addr", ret_addr, e_ret);
        chk(unlock == e_unl, "R10", "unlock", 64'(unlock), 64'(e_unl));
    endtask

    task automatic clear();
        {req_mchk, req_arith, req_intr, req_corr, req_dserr} = '0;
        {req_itbm, req_iacv, req_call, req_illop, req_fpdis} = '0;
    endtask

    task automatic set_ev(input int k);
        case (k)
            0: rst = 1;
            1: req_mchk = 1;
            2: req_arith = 1;
            3: req_intr = 1;
            4: req_dserr = 1;
            5: req_itbm = 1;
            6: req_iacv = 1;
            7: req_call = 1;
            8: req_illop = 1;
            default: req_fpdis = 1;
        endcase
    endtask

    task automatic new_pcs();
        fault_pc = {$urandom, $urandom};
        next_pc  = fault_pc + 64'd4;
    endtask

    initial begin
        rst = 1; clear(); dserr_class = 0; call_func = 0; in_kernel = 1;
        fault_pc = 64'h1000; next_pc = 64'h1004;
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc(); cyc();

        // Single events (R2)
        for (int k = 1; k <= 9; k++) begin
            clear(); set_ev(k); call_func = 8'h85; new_pcs(); cyc();
            clear(); cyc();
        end
        // Data-stream classes (R3)
        for (int c = 0; c < 4; c++) begin
            clear(); req_dserr = 1; dserr_class = 2'(c); new_pcs(); cyc();
        end
        // Corrected error (R12)
        clear(); req_corr = 1; new_pcs(); cyc();
        clear(); cyc();
        // Every call code in both modes (R4..R7)
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 256; f++) begin
                clear(); req_call = 1; call_func = 8'(f); in_kernel = m[0];
                new_pcs(); cyc();
            end
        end
        // Every pair of ranked events together (R8)
        force_tag = "R8";
        for (int i = 0; i <= 9; i++) begin
            for (int j = i + 1; j <= 9; j++) begin
                clear(); rst = 0; set_ev(i); set_ev(j);
                call_func = 8'h05; in_kernel = 1; dserr_class = 2'd2;
                new_pcs(); cyc();
                rst = 0; clear(); cyc();
            end
        end
        force_tag = "";
        // Random mixture
        for (int n = 0; n < 3000; n++) begin
            clear();
            rst       = ($urandom_range(0, 99) == 0);
            req_mchk  = ($urandom_range(0, 15) == 0);
            req_arith = ($urandom_range(0, 11) == 0);
            req_intr  = ($urandom_range(0, 9) == 0);
            req_corr  = ($urandom_range(0, 9) == 0);
            req_dserr = ($urandom_range(0, 7) == 0);
            req_itbm  = ($urandom_range(0, 7) == 0);
            req_iacv  = ($urandom_range(0, 7) == 0);
            req_call  = ($urandom_range(0, 3) == 0);
            req_illop = ($urandom_range(0, 7) == 0);
            req_fpdis = ($urandom_range(0, 7) == 0);
            dserr_class = 2'($urandom);
            call_func   = 8'($urandom);
            in_kernel   = 1'($urandom);
            new_pcs();
            cyc();
        end
        rst = 0; clear(); cyc();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule